// File: doc/BRIEF.md
# Dual-Gain Pixel Stream Merger

This block merges two 12-bit pixel streams into one linear 16-bit stream. Both streams carry the same pixel, sampled at the same instant: one through a high-gain amplifier (low noise, small range) and one through a low-gain amplifier (higher noise, full range). For every pixel the block compares the high-gain sample against a programmable threshold. If the sample is below it, the high-gain reading is kept; otherwise the low-gain reading is used. The kept sample is then corrected with the per-pixel offset and gain coefficients that belong to its own channel. These coefficients arrive as side-band inputs aligned with the pixel.

The gain coefficient is unsigned Q5.11. It holds both the pixel-to-pixel response correction and the ratio between the two channels, so both readings end up on one common scale. A low-gain pixel typically needs a factor near 16 relative to a high-gain pixel. The result is rounded to nearest and saturated to 16 bits. Two bypass modes force one channel for single-channel operation, with correction still applied. The pipeline has no handshake and a fixed latency. The valid, start-of-frame and end-of-line markers travel alongside the data. A side-band bit reports which channel produced each output pixel.

A small frame controller has two states. ST_WAIT is entered at reset, and pixels arriving there without a start-of-frame marker are discarded. The transition T_FRAME_START moves to ST_RUN on a valid start-of-frame pixel. ST_RUN accepts every valid pixel. The transition T_FRAME_RESTART stays in ST_RUN and captures the configuration again on each later start-of-frame pixel.

Top module: `dgain_merge`

## Requirements
- R1: In merge mode (mode code 00 or 11) the high-gain sample is used when it is strictly less than the frame threshold, and the low-gain sample is used otherwise. `pix_chan_o` is 0 for the high-gain channel and 1 for the low-gain channel.
- R2: The threshold and the mode are captured from the valid pixel that carries start-of-frame, and that pixel already uses the new values. Changes to `threshold_i` or `mode_i` on other pixels have no effect until the next start-of-frame.
- R3: The chosen channel's 12-bit offset is subtracted from the chosen sample. A negative difference becomes 0.
- R4: The difference d is multiplied by the chosen channel's Q5.11 gain g and rounded: result = floor((d*g + 1024) / 2048).
- R5: A result above 65535 is output as 65535.
- R6: An input pixel sampled on one rising edge appears on the outputs after the third rising edge, counting that edge as the first. Valid, start-of-frame, end-of-line and the channel bit are delayed by the same amount as the data.
- R7: Mode code 01 always uses the high-gain channel and its coefficients. Mode code 10 always uses the low-gain channel and its coefficients.
- R8: After reset, all outputs are 0. Valid pixels that arrive before the first start-of-frame pixel produce no output valid.
- R9: A cycle with `pix_valid_i` low produces no output valid, no output markers and no configuration capture, even if `pix_sof_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid_i | input | 1 | Input pixel is valid this cycle |
| pix_sof_i | input | 1 | First pixel of a frame |
| pix_eol_i | input | 1 | Last pixel of a line |
| hi_sample_i | input | 12 | High-gain channel sample |
| lo_sample_i | input | 12 | Low-gain channel sample |
| hi_offset_i | input | 12 | High-gain offset for this pixel |
| hi_gain_i | input | 16 | High-gain Q5.11 gain for this pixel |
| lo_offset_i | input | 12 | Low-gain offset for this pixel |
| lo_gain_i | input | 16 | Low-gain Q5.11 gain for this pixel |
| threshold_i | input | 12 | Channel switch threshold, captured at start-of-frame |
| mode_i | input | 2 | 00/11 merge, 01 high only, 10 low only; captured at start-of-frame |
| pix_o | output | 16 | Corrected merged pixel |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_sof_o | output | 1 | Output start-of-frame marker |
| pix_eol_o | output | 1 | Output end-of-line marker |
| pix_chan_o | output | 1 | Channel used: 0 high gain, 1 low gain |

## Verification
The assertions assume that the side-band coefficients are aligned with the pixel they belong to in the same cycle. They also assume that the configuration inputs only matter on a valid start-of-frame pixel. The latency assertions relate output markers to input markers three cycles earlier, so they assume no input is sampled during reset. The stimulus drives every input on the falling edge and holds reset for several cycles before any pixel. It changes the threshold and mode only between pixels, sometimes deliberately off a start-of-frame pixel, to show that such changes are ignored.

// File: rtl/dgm_pkg.sv
package dgm_pkg;
    localparam int unsigned SAMPLE_W  = 12;
    localparam int unsigned GAIN_W    = 16;
    localparam int unsigned GAIN_FRAC = 11;
    localparam int unsigned OUT_W     = 16;

    typedef enum logic [1:0] {
        MODE_MERGE     = 2'b00,
        MODE_HIGH      = 2'b01,
        MODE_LOW       = 2'b10,
        MODE_MERGE_ALT = 2'b11
    } merge_mode_e;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } frame_state_e;

    typedef struct packed {
        logic valid;
        logic sof;
        logic eol;
        logic chan;
    } pix_tag_t;
endpackage

// File: rtl/dgm_frame_ctl.sv
module dgm_frame_ctl
    import dgm_pkg::*;
#(
    parameter int unsigned SW = SAMPLE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid_i,
    input  logic          pix_sof_i,
    input  logic [SW-1:0] thr_i,
    input  logic [1:0]    mode_i,
    output logic          accept_o,
    output logic [SW-1:0] thr_eff_o,
    output merge_mode_e   mode_eff_o
);
    frame_state_e state_q, state_d;
    logic [SW-1:0] thr_q;
    merge_mode_e   mode_q;
    logic          start;

    assign start = pix_valid_i & pix_sof_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // frame configuration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q  <= '1;
            mode_q <= MODE_MERGE;
        end else if (start) begin
            thr_q  <= thr_i;
            mode_q <= merge_mode_e'(mode_i);
        end
    end

    // next state: T_FRAME_START, T_FRAME_RESTART
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (start) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        accept_o   = 1'b0;
        thr_eff_o  = thr_q;
        mode_eff_o = mode_q;
        unique case (state_q)
            ST_WAIT: accept_o = start;
            ST_RUN:  accept_o = pix_valid_i;
        endcase
        if (start) begin
            thr_eff_o  = thr_i;
            mode_eff_o = merge_mode_e'(mode_i);
        end
    end

    assert_thr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(thr_q) && $stable(mode_q)));
    assert_wait_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !pix_sof_i) |-> !accept_o);
endmodule

// File: rtl/dgm_select.sv
module dgm_select
    import dgm_pkg::*;
#(
    parameter int unsigned SW = SAMPLE_W,
    parameter int unsigned GW = GAIN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic          sof_i,
    input  logic          eol_i,
    input  logic [SW-1:0] thr_i,
    input  merge_mode_e   mode_i,
    input  logic [SW-1:0] hi_i,
    input  logic [SW-1:0] lo_i,
    input  logic [SW-1:0] off_hi_i,
    input  logic [GW-1:0] gain_hi_i,
    input  logic [SW-1:0] off_lo_i,
    input  logic [GW-1:0] gain_lo_i,
    output pix_tag_t      tag_o,
    output logic [SW-1:0] sample_o,
    output logic [SW-1:0] off_o,
    output logic [GW-1:0] gain_o
);
    logic use_lo;

    always_comb begin
        use_lo = 1'b0;
        unique case (mode_i)
            MODE_HIGH:      use_lo = 1'b0;
            MODE_LOW:       use_lo = 1'b1;
            MODE_MERGE,
            MODE_MERGE_ALT: use_lo = !(hi_i < thr_i);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_o    <= '0;
            sample_o <= '0;
            off_o    <= '0;
            gain_o   <= '0;
        end else begin
            tag_o.valid <= accept_i;
            tag_o.sof   <= accept_i & sof_i;
            tag_o.eol   <= accept_i & eol_i;
            tag_o.chan  <= use_lo;
            sample_o    <= use_lo ? lo_i     : hi_i;
            off_o       <= use_lo ? off_lo_i : off_hi_i;
            gain_o      <= use_lo ? gain_lo_i : gain_hi_i;
        end
    end

    assert_merge_pick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && (mode_i == MODE_MERGE || mode_i == MODE_MERGE_ALT))
        |=> (tag_o.chan == ($past(hi_i) >= $past(thr_i))));
    assert_bypass_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && mode_i == MODE_LOW) |=> (tag_o.chan && sample_o == $past(lo_i)));
    assert_bypass_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && mode_i == MODE_HIGH) |=> (!tag_o.chan && sample_o == $past(hi_i)));
endmodule

// File: rtl/dgm_offset.sv
module dgm_offset
    import dgm_pkg::*;
#(
    parameter int unsigned SW = SAMPLE_W,
    parameter int unsigned GW = GAIN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pix_tag_t      tag_i,
    input  logic [SW-1:0] sample_i,
    input  logic [SW-1:0] off_i,
    input  logic [GW-1:0] gain_i,
    output pix_tag_t      tag_o,
    output logic [SW-1:0] diff_o,
    output logic [GW-1:0] gain_o
);
    logic [SW-1:0] diff_w;

    always_comb begin
        diff_w = '0;
        if (sample_i > off_i) diff_w = sample_i - off_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_o  <= '0;
            diff_o <= '0;
            gain_o <= '0;
        end else begin
            tag_o  <= tag_i;
            diff_o <= diff_w;
            gain_o <= gain_i;
        end
    end

    assert_clamp_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_i.valid && sample_i < off_i) |=> (diff_o == '0));
endmodule

// File: rtl/dgm_scale.sv
module dgm_scale
    import dgm_pkg::*;
#(
    parameter int unsigned SW   = SAMPLE_W,
    parameter int unsigned GW   = GAIN_W,
    parameter int unsigned FRAC = GAIN_FRAC,
    parameter int unsigned OW   = OUT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pix_tag_t      tag_i,
    input  logic [SW-1:0] diff_i,
    input  logic [GW-1:0] gain_i,
    output pix_tag_t      tag_o,
    output logic [OW-1:0] pix_o
);
    localparam int unsigned SUM_W = SW + GW + 1;
    localparam logic [SUM_W-1:0] HALF    = SUM_W'(1) << (FRAC - 1);
    localparam logic [SUM_W-1:0] MAX_OUT = {{(SUM_W-OW){1'b0}}, {OW{1'b1}}};

    logic [SUM_W-1:0] prod_w;
    logic [SUM_W-1:0] rnd_w;
    logic [OW-1:0]    sat_w;

    assign prod_w = SUM_W'(diff_i) * SUM_W'(gain_i);
    assign rnd_w  = (prod_w + HALF) >> FRAC;
    assign sat_w  = (rnd_w > MAX_OUT) ? {OW{1'b1}} : rnd_w[OW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_o <= '0;
            pix_o <= '0;
        end else begin
            tag_o <= tag_i;
            pix_o <= sat_w;
        end
    end

    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_i.valid && rnd_w > MAX_OUT) |=> (pix_o == {OW{1'b1}}));
    assert_zero_in_zero_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_i.valid && diff_i == '0) |=> (pix_o == '0));
endmodule

// File: rtl/dgain_merge.sv
module dgain_merge
    import dgm_pkg::*;
#(
    parameter int unsigned SW   = SAMPLE_W,
    parameter int unsigned GW   = GAIN_W,
    parameter int unsigned FRAC = GAIN_FRAC,
    parameter int unsigned OW   = OUT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid_i,
    input  logic          pix_sof_i,
    input  logic          pix_eol_i,
    input  logic [SW-1:0] hi_sample_i,
    input  logic [SW-1:0] lo_sample_i,
    input  logic [SW-1:0] hi_offset_i,
    input  logic [GW-1:0] hi_gain_i,
    input  logic [SW-1:0] lo_offset_i,
    input  logic [GW-1:0] lo_gain_i,
    input  logic [SW-1:0] threshold_i,
    input  logic [1:0]    mode_i,
    output logic [OW-1:0] pix_o,
    output logic          pix_valid_o,
    output logic          pix_sof_o,
    output logic          pix_eol_o,
    output logic          pix_chan_o
);
    logic          accept;
    logic [SW-1:0] thr_eff;
    merge_mode_e   mode_eff;
    pix_tag_t      tag_s1, tag_s2, tag_s3;
    logic [SW-1:0] sample_s1, off_s1, diff_s2;
    logic [GW-1:0] gain_s1, gain_s2;

    dgm_frame_ctl #(.SW(SW)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .pix_valid_i(pix_valid_i), .pix_sof_i(pix_sof_i),
        .thr_i(threshold_i), .mode_i(mode_i),
        .accept_o(accept), .thr_eff_o(thr_eff), .mode_eff_o(mode_eff)
    );

    dgm_select #(.SW(SW), .GW(GW)) u_sel (
        .clk(clk), .rst_n(rst_n),
        .accept_i(accept), .sof_i(pix_sof_i), .eol_i(pix_eol_i),
        .thr_i(thr_eff), .mode_i(mode_eff),
        .hi_i(hi_sample_i), .lo_i(lo_sample_i),
        .off_hi_i(hi_offset_i), .gain_hi_i(hi_gain_i),
        .off_lo_i(lo_offset_i), .gain_lo_i(lo_gain_i),
        .tag_o(tag_s1), .sample_o(sample_s1), .off_o(off_s1), .gain_o(gain_s1)
    );

    dgm_offset #(.SW(SW), .GW(GW)) u_off (
        .clk(clk), .rst_n(rst_n),
        .tag_i(tag_s1), .sample_i(sample_s1), .off_i(off_s1), .gain_i(gain_s1),
        .tag_o(tag_s2), .diff_o(diff_s2), .gain_o(gain_s2)
    );

    dgm_scale #(.SW(SW), .GW(GW), .FRAC(FRAC), .OW(OW)) u_scl (
        .clk(clk), .rst_n(rst_n),
        .tag_i(tag_s2), .diff_i(diff_s2), .gain_i(gain_s2),
        .tag_o(tag_s3), .pix_o(pix_o)
    );

    assign pix_valid_o = tag_s3.valid;
    assign pix_sof_o   = tag_s3.sof;
    assign pix_eol_o   = tag_s3.eol;
    assign pix_chan_o  = tag_s3.chan;

    assert_latency_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o |-> $past(pix_valid_i, 3));
    assert_latency_sof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sof_o |-> ($past(pix_sof_i, 3) && pix_valid_o));
    assert_latency_eol_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_eol_o |-> ($past(pix_eol_i, 3) && pix_valid_o));
    assert_no_valid_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pix_valid_i, 3) |-> !pix_valid_o);
endmodule

// File: tb/dgain_merge_tb_top.sv
module dgain_merge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid_i = 1'b0, pix_sof_i = 1'b0, pix_eol_i = 1'b0;
    logic [11:0] hi_sample_i = '0, lo_sample_i = '0, hi_offset_i = '0, lo_offset_i = '0;
    logic [15:0] hi_gain_i = '0, lo_gain_i = '0;
    logic [11:0] threshold_i = '0;
    logic [1:0]  mode_i = '0;
    logic [15:0] pix_o;
    logic        pix_valid_o, pix_sof_o, pix_eol_o, pix_chan_o;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dgain_merge dut_i (
        .clk(clk), .rst_n(rst_n),
        .pix_valid_i(pix_valid_i), .pix_sof_i(pix_sof_i), .pix_eol_i(pix_eol_i),
        .hi_sample_i(hi_sample_i), .lo_sample_i(lo_sample_i),
        .hi_offset_i(hi_offset_i), .hi_gain_i(hi_gain_i),
        .lo_offset_i(lo_offset_i), .lo_gain_i(lo_gain_i),
        .threshold_i(threshold_i), .mode_i(mode_i),
        .pix_o(pix_o), .pix_valid_o(pix_valid_o), .pix_sof_o(pix_sof_o),
        .pix_eol_o(pix_eol_o), .pix_chan_o(pix_chan_o)
    );

    typedef struct packed {
        logic        sof;
        logic        eol;
        logic [11:0] hi;
        logic [11:0] lo;
        logic [11:0] offh;
        logic [15:0] gh;
        logic [11:0] offl;
        logic [15:0] gl;
        logic        echan;
        logic [15:0] eval;
    } vec_t;

    localparam int NV = 8;
    // threshold 2000, merge mode
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 12'd100,  12'd10,   12'd50, 16'd2048, 12'd5,  16'd32768, 1'b0, 16'd50},
        '{1'b0, 1'b0, 12'd1999, 12'd125,  12'd0,  16'd3072, 12'd0,  16'd32768, 1'b0, 16'd2999},
        '{1'b0, 1'b0, 12'd2000, 12'd130,  12'd0,  16'd2048, 12'd10, 16'd32768, 1'b1, 16'd1920},
        '{1'b0, 1'b0, 12'd4095, 12'd4095, 12'd0,  16'd2048, 12'd0,  16'd65535, 1'b1, 16'd65535},
        '{1'b0, 1'b0, 12'd4095, 12'd3,    12'd0,  16'd2048, 12'd10, 16'd32768, 1'b1, 16'd0},
        '{1'b0, 1'b0, 12'd30,   12'd500,  12'd40, 16'd2048, 12'd0,  16'd2048,  1'b0, 16'd0},
        '{1'b0, 1'b0, 12'd1,    12'd0,    12'd0,  16'd1024, 12'd0,  16'd2048,  1'b0, 16'd1},
        '{1'b0, 1'b1, 12'd3,    12'd0,    12'd0,  16'd341,  12'd0,  16'd2048,  1'b0, 16'd0}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic sof, input logic eol,
                         input int thr, input int mode, input int hi, input int lo,
                         input int offh, input int gh, input int offl, input int gl);
        pix_valid_i = v; pix_sof_i = sof; pix_eol_i = eol;
        threshold_i = 12'(thr); mode_i = 2'(mode);
        hi_sample_i = 12'(hi); lo_sample_i = 12'(lo);
        hi_offset_i = 12'(offh); hi_gain_i = 16'(gh);
        lo_offset_i = 12'(offl); lo_gain_i = 16'(gl);
    endtask

    task automatic idle();
        pix_valid_i = 1'b0; pix_sof_i = 1'b0; pix_eol_i = 1'b0;
    endtask

    // drive one pixel at a falling edge, return after the third rising edge
    task automatic send(input logic sof, input int thr, input int mode, input int hi,
                        input int lo, input int offh, input int gh, input int offl, input int gl);
        @(negedge clk);
        drive(1'b1, sof, 1'b0, thr, mode, hi, lo, offh, gh, offl, gl);
        @(negedge clk); idle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R8: reset state
        check("R8", "reset pix_o", int'(pix_o), 0);
        check("R8", "reset valid", int'(pix_valid_o), 0);
        rst_n = 1'b1;
        // R8: pixel before first start-of-frame is dropped
        send(1'b0, 2000, 0, 100, 10, 0, 2048, 0, 2048);
        check("R8", "pre-frame valid", int'(pix_valid_o), 0);
        @(negedge clk);
        check("R8", "pre-frame valid next", int'(pix_valid_o), 0);

        // table walk: R1 R3 R4 R5 R6
        for (int i = 0; i < NV + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                check("R6", "table valid", int'(pix_valid_o), 1);
                check("R6", "table sof", int'(pix_sof_o), int'(VEC[i-3].sof));
                check("R6", "table eol", int'(pix_eol_o), int'(VEC[i-3].eol));
                check("R1", "table chan", int'(pix_chan_o), int'(VEC[i-3].echan));
                check("R4", "table pix", int'(pix_o), int'(VEC[i-3].eval));
            end
            if (i < NV)
                drive(1'b1, VEC[i].sof, VEC[i].eol, 2000, 0, VEC[i].hi, VEC[i].lo,
                      VEC[i].offh, VEC[i].gh, VEC[i].offl, VEC[i].gl);
            else
                idle();
        end
        @(negedge clk);
        check("R6", "drain valid", int'(pix_valid_o), 0);

        // R6: exact latency of a lone pixel
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b1, 2000, 0, 700, 0, 0, 2048, 0, 2048);
        @(negedge clk); idle();
        @(negedge clk);
        check("R6", "valid after two edges", int'(pix_valid_o), 0);
        @(negedge clk);
        check("R6", "valid after three edges", int'(pix_valid_o), 1);
        check("R6", "eol after three edges", int'(pix_eol_o), 1);
        check("R6", "pix after three edges", int'(pix_o), 700);

        // R2: threshold captured at start-of-frame only
        send(1'b1, 2000, 0, 1500, 90, 0, 2048, 0, 32768);
        check("R2", "sof thr 2000 chan", int'(pix_chan_o), 0);
        check("R2", "sof thr 2000 pix", int'(pix_o), 1500);
        send(1'b0, 1000, 0, 1500, 90, 0, 2048, 0, 32768);
        check("R2", "mid-frame thr change chan", int'(pix_chan_o), 0);
        check("R2", "mid-frame thr change pix", int'(pix_o), 1500);
        send(1'b1, 1000, 0, 1500, 90, 0, 2048, 0, 32768);
        check("R2", "new sof thr 1000 chan", int'(pix_chan_o), 1);
        check("R1", "low channel x16 pix", int'(pix_o), 1440);

        // R7: bypass modes
        send(1'b1, 1000, 1, 3000, 7, 0, 2048, 0, 2048);
        check("R7", "high-only chan", int'(pix_chan_o), 0);
        check("R7", "high-only pix", int'(pix_o), 3000);
        send(1'b1, 1000, 2, 5, 7, 0, 2048, 0, 2048);
        check("R7", "low-only chan", int'(pix_chan_o), 1);
        check("R7", "low-only pix", int'(pix_o), 7);
        send(1'b0, 1000, 1, 5, 7, 0, 2048, 0, 2048);
        check("R2", "mid-frame mode change chan", int'(pix_chan_o), 1);

        // R9: invalid cycle with sof high is ignored
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b1, 4095, 0, 5, 7, 0, 2048, 0, 2048);
        @(negedge clk); idle();
        @(negedge clk);
        @(negedge clk);
        check("R9", "invalid valid_o", int'(pix_valid_o), 0);
        check("R9", "invalid sof_o", int'(pix_sof_o), 0);
        check("R9", "invalid eol_o", int'(pix_eol_o), 0);
        send(1'b0, 4095, 0, 5, 7, 0, 2048, 0, 2048);
        check("R9", "mode kept after invalid sof", int'(pix_chan_o), 1);
        check("R9", "pix after invalid sof", int'(pix_o), 7);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule